// File: doc/BRIEF.md
# Doubleword Load/Store Decode and Address Stage

This block is one registered decode stage of a 64-bit integer core. Each cycle it can accept one 32-bit instruction word together with the current contents of the base and index registers. It recognises the doubleword load and store family and the sign-extending word load that shares its opcode space. These come in two address forms: a scaled-displacement form and a register-indexed form, each with and without base update.

For a recognised instruction the stage reports the access kind, size and sign extension, and the register numbers involved. It also computes the 64-bit effective address, asks for the base register to be overwritten with that address on update forms, and flags update forms whose register choice is not permitted. The results are registered, so they appear one clock after the input is presented. Memory access, the register file and hazard handling belong to other blocks.

Top module: `dw_ldst_decode`

## Requirements
- R1: While `rst_n` is low, every output reads zero, whatever the inputs are.
- R2: Results appear exactly one clock after the input is taken. A cycle with `in_valid` low yields `out_valid` low and all other outputs zero on the next cycle.
- R3: Primary opcode 58 (bits 31:26) is the scaled-displacement load group, selected by bits 1:0. Value 0 is a doubleword load and 1 is a doubleword load with update, both with `out_size`=3 and `out_sext`=0. Value 2 is a word load with `out_size`=2 and `out_sext`=1. All three give `out_kind`=0 (load).
- R4: Primary opcode 62 is the scaled-displacement store group. Bits 1:0 equal to 0 give a doubleword store and 1 gives a doubleword store with update. Both report `out_kind`=1, `out_size`=3 and `out_sext`=0.
- R5: Under primary opcode 31, the extended opcode in bits 10:1 selects an indexed form. Value 21 is a load, 53 a load with update, 149 a store and 181 a store with update. All are doubleword accesses with no sign extension.
- R6: In scaled-displacement forms, the 14-bit field in bits 15:2 is sign-extended, multiplied by four and added to the base value. The effective address wraps modulo 2^64.
- R7: On forms without update, a base field (bits 20:16) of zero makes the base value read as zero. On update forms the base value is always used.
- R8: In indexed forms the effective address is base value plus index value, wrapping modulo 2^64.
- R9: `out_rt` carries bits 25:21 and `out_ra` carries bits 20:16. `out_wb_en` is high exactly for a permitted update form, and it means that `out_ea` is to be written to register `out_ra`.
- R10: A load with update is flagged `out_illegal` when its base field is zero or equals its target field. Such a load raises no writeback.
- R11: A store with update is flagged `out_illegal` only when its base field is zero. A store whose base field equals its source field is accepted.
- R12: Any other opcode, sub-opcode or extended opcode gives `out_valid` low, with all other outputs zero, including `out_wb_en` and `out_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word presented this cycle |
| in_insn | input | 32 | Instruction word |
| in_base | input | 64 | Value of the register named by bits 20:16 |
| in_index | input | 64 | Value of the register named by bits 15:11 |
| out_valid | output | 1 | Recognised instruction decoded |
| out_kind | output | 1 | 0 load, 1 store |
| out_size | output | 2 | log2 of access bytes (2 word, 3 doubleword) |
| out_sext | output | 1 | Load result is sign-extended |
| out_rt | output | 5 | Target (load) or source (store) register |
| out_ra | output | 5 | Base register |
| out_ea | output | 64 | Effective address |
| out_wb_en | output | 1 | Write out_ea back to out_ra |
| out_illegal | output | 1 | Update form with a forbidden register choice |

## Verification
Every result of this stage passes through one register, so each of them is due on the clock edge that follows the edge that takes the input. The bench applies one instruction on a falling edge and reads all outputs on the next falling edge, after exactly one rising edge. An idle cycle is checked the same way, one edge later. A sweep covers every recognised form, every base register number, several target choices and wrap-around displacements and indices. A second sweep covers all 1024 extended opcodes and the unused sub-opcodes.

// File: rtl/dw_ldst_pkg.sv
`timescale 1ns/1ps
package dw_ldst_pkg;
    localparam int INSN_W = 32;
    localparam int OPC_W  = 6;
    localparam int XO_W   = 10;
    localparam int SUB_W  = 2;

    localparam logic [OPC_W-1:0] OPC_DS_LOAD  = 6'd58;
    localparam logic [OPC_W-1:0] OPC_DS_STORE = 6'd62;
    localparam logic [OPC_W-1:0] OPC_XGROUP   = 6'd31;

    localparam logic [XO_W-1:0] XO_LOAD      = 10'd21;
    localparam logic [XO_W-1:0] XO_LOAD_UPD  = 10'd53;
    localparam logic [XO_W-1:0] XO_STORE     = 10'd149;
    localparam logic [XO_W-1:0] XO_STORE_UPD = 10'd181;

    localparam logic [1:0] SZ_WORD  = 2'd2;
    localparam logic [1:0] SZ_DWORD = 2'd3;

    typedef enum logic {
        KIND_LOAD  = 1'b0,
        KIND_STORE = 1'b1
    } kind_e;

    typedef struct packed {
        logic       hit;
        kind_e      kind;
        logic [1:0] size;
        logic       sext;
        logic       update;
        logic       indexed;
    } dec_t;
endpackage

// File: rtl/dw_ldst_classify.sv
`timescale 1ns/1ps
module dw_ldst_classify
    import dw_ldst_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  logic [XO_W-1:0]  xo,
    input  logic [SUB_W-1:0] sub,
    output dec_t             dec
);
    always_comb begin
        dec      = '0;
        dec.kind = KIND_LOAD;
        dec.size = SZ_DWORD;
        case (opc)
            OPC_DS_LOAD: begin
                case (sub)
                    2'd0: dec.hit = 1'b1;
                    2'd1: begin
                        dec.hit    = 1'b1;
                        dec.update = 1'b1;
                    end
                    2'd2: begin
                        dec.hit  = 1'b1;
                        dec.size = SZ_WORD;
                        dec.sext = 1'b1;
                    end
                    default: dec.hit = 1'b0;
                endcase
            end
            OPC_DS_STORE: begin
                dec.kind = KIND_STORE;
                case (sub)
                    2'd0: dec.hit = 1'b1;
                    2'd1: begin
                        dec.hit    = 1'b1;
                        dec.update = 1'b1;
                    end
                    default: dec.hit = 1'b0;
                endcase
            end
            OPC_XGROUP: begin
                dec.indexed = 1'b1;
                case (xo)
                    XO_LOAD: dec.hit = 1'b1;
                    XO_LOAD_UPD: begin
                        dec.hit    = 1'b1;
                        dec.update = 1'b1;
                    end
                    XO_STORE: begin
                        dec.hit  = 1'b1;
                        dec.kind = KIND_STORE;
                    end
                    XO_STORE_UPD: begin
                        dec.hit    = 1'b1;
                        dec.kind   = KIND_STORE;
                        dec.update = 1'b1;
                    end
                    default: dec.hit = 1'b0;
                endcase
            end
            default: dec.hit = 1'b0;
        endcase
        if (!dec.hit) begin
            dec = '0;
        end
    end
endmodule

// File: rtl/dw_ldst_agen.sv
`timescale 1ns/1ps
module dw_ldst_agen #(
    parameter int XLEN     = 64,
    parameter int DISP_W   = 14,
    parameter int DS_SHIFT = 2
) (
    input  logic              indexed,
    input  logic              zero_base,
    input  logic [DISP_W-1:0] disp,
    input  logic [XLEN-1:0]   base,
    input  logic [XLEN-1:0]   index,
    output logic [XLEN-1:0]   ea
);
    localparam int EXT_W = XLEN - DISP_W;

    logic [XLEN-1:0] disp_sx;
    logic [XLEN-1:0] disp_sc;
    logic [XLEN-1:0] base_eff;
    logic [XLEN-1:0] offset;

    always_comb begin
        disp_sx  = {{EXT_W{disp[DISP_W-1]}}, disp};
        disp_sc  = disp_sx << DS_SHIFT;
        base_eff = zero_base ? '0 : base;
        offset   = indexed ? index : disp_sc;
        ea       = base_eff + offset;
    end
endmodule

// File: rtl/dw_ldst_legal.sv
`timescale 1ns/1ps
module dw_ldst_legal
    import dw_ldst_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             hit,
    input  logic             update,
    input  kind_e            kind,
    input  logic [REG_W-1:0] ra,
    input  logic [REG_W-1:0] rt,
    output logic             illegal,
    output logic             wb_req
);
    logic ra_zero;
    logic ra_clash;

    always_comb begin
        ra_zero  = (ra == '0);
        ra_clash = (kind == KIND_LOAD) && (ra == rt);
        illegal  = hit && update && (ra_zero || ra_clash);
        wb_req   = hit && update && !illegal;
    end
endmodule

// File: rtl/dw_ldst_decode.sv
`timescale 1ns/1ps
module dw_ldst_decode
    import dw_ldst_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int REG_W    = 5,
    parameter int DISP_W   = 14,
    parameter int DS_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_insn,
    input  logic [XLEN-1:0]   in_base,
    input  logic [XLEN-1:0]   in_index,
    output logic              out_valid,
    output logic              out_kind,
    output logic [1:0]        out_size,
    output logic              out_sext,
    output logic [REG_W-1:0]  out_rt,
    output logic [REG_W-1:0]  out_ra,
    output logic [XLEN-1:0]   out_ea,
    output logic              out_wb_en,
    output logic              out_illegal
);
    localparam int OPC_LO  = INSN_W - OPC_W;
    localparam int RT_LO   = OPC_LO - REG_W;
    localparam int RA_LO   = RT_LO - REG_W;
    localparam int DISP_LO = SUB_W;
    localparam int XO_LO   = 1;

    typedef struct packed {
        logic             valid;
        kind_e            kind;
        logic [1:0]       size;
        logic             sext;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] ra;
        logic [XLEN-1:0]  ea;
        logic             wb;
        logic             illegal;
    } stage_t;

    logic [OPC_W-1:0]  f_opc;
    logic [REG_W-1:0]  f_rt;
    logic [REG_W-1:0]  f_ra;
    logic [DISP_W-1:0] f_disp;
    logic [XO_W-1:0]   f_xo;
    logic [SUB_W-1:0]  f_sub;

    assign f_opc  = in_insn[OPC_LO +: OPC_W];
    assign f_rt   = in_insn[RT_LO +: REG_W];
    assign f_ra   = in_insn[RA_LO +: REG_W];
    assign f_disp = in_insn[DISP_LO +: DISP_W];
    assign f_xo   = in_insn[XO_LO +: XO_W];
    assign f_sub  = in_insn[0 +: SUB_W];

    dec_t            dec;
    logic            zero_base;
    logic [XLEN-1:0] ea_w;
    logic            illegal_w;
    logic            wb_w;

    dw_ldst_classify u_classify (
        .opc (f_opc),
        .xo  (f_xo),
        .sub (f_sub),
        .dec (dec)
    );

    assign zero_base = (f_ra == '0) && !dec.update;

    dw_ldst_agen #(
        .XLEN     (XLEN),
        .DISP_W   (DISP_W),
        .DS_SHIFT (DS_SHIFT)
    ) u_agen (
        .indexed   (dec.indexed),
        .zero_base (zero_base),
        .disp      (f_disp),
        .base      (in_base),
        .index     (in_index),
        .ea        (ea_w)
    );

    dw_ldst_legal #(
        .REG_W (REG_W)
    ) u_legal (
        .hit     (dec.hit),
        .update  (dec.update),
        .kind    (dec.kind),
        .ra      (f_ra),
        .rt      (f_rt),
        .illegal (illegal_w),
        .wb_req  (wb_w)
    );

    stage_t stage_d;
    stage_t stage_q;

    always_comb begin
        stage_d = '0;
        if (in_valid && dec.hit) begin
            stage_d.valid   = 1'b1;
            stage_d.kind    = dec.kind;
            stage_d.size    = dec.size;
            stage_d.sext    = dec.sext;
            stage_d.rt      = f_rt;
            stage_d.ra      = f_ra;
            stage_d.ea      = ea_w;
            stage_d.wb      = wb_w;
            stage_d.illegal = illegal_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid   = stage_q.valid;
    assign out_kind    = stage_q.kind;
    assign out_size    = stage_q.size;
    assign out_sext    = stage_q.sext;
    assign out_rt      = stage_q.rt;
    assign out_ra      = stage_q.ra;
    assign out_ea      = stage_q.ea;
    assign out_wb_en   = stage_q.wb;
    assign out_illegal = stage_q.illegal;
endmodule

// File: rtl/dw_ldst_decode_chk.sv
`timescale 1ns/1ps
module dw_ldst_decode_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic             out_kind,
    input logic [1:0]       out_size,
    input logic             out_sext,
    input logic [REG_W-1:0] out_rt,
    input logic [REG_W-1:0] out_ra,
    input logic             out_wb_en,
    input logic             out_illegal
);
    AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2

    AST_QUIET_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_wb_en && !out_illegal && out_size == 2'd0)); // R12

    AST_SEXT_ONLY_WORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sext) |-> (out_size == 2'd2 && !out_kind)); // R3

    AST_STORE_DWORD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind) |-> (out_size == 2'd3 && !out_sext)); // R4

    AST_WB_BASE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_wb_en |-> (out_valid && out_ra != '0 && !out_illegal)); // R9

    AST_LOAD_UPD_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (out_illegal && out_ra != '0) |-> (!out_kind && out_ra == out_rt)); // R10

    AST_STORE_ILLEGAL_BASE0: assert property (@(posedge clk) disable iff (!rst_n)
        (out_illegal && out_kind) |-> (out_ra == '0)); // R11
endmodule

bind dw_ldst_decode dw_ldst_decode_chk #(.REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_kind    (out_kind),
    .out_size    (out_size),
    .out_sext    (out_sext),
    .out_rt      (out_rt),
    .out_ra      (out_ra),
    .out_wb_en   (out_wb_en),
    .out_illegal (out_illegal)
);

// File: tb/dw_ldst_decode_test.sv
`timescale 1ns/1ps
module dw_ldst_decode_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_insn;
    logic [63:0] in_base;
    logic [63:0] in_index;
    logic        out_valid;
    logic        out_kind;
    logic [1:0]  out_size;
    logic        out_sext;
    logic [4:0]  out_rt;
    logic [4:0]  out_ra;
    logic [63:0] out_ea;
    logic        out_wb_en;
    logic        out_illegal;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    dw_ldst_decode uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_insn     (in_insn),
        .in_base     (in_base),
        .in_index    (in_index),
        .out_valid   (out_valid),
        .out_kind    (out_kind),
        .out_size    (out_size),
        .out_sext    (out_sext),
        .out_rt      (out_rt),
        .out_ra      (out_ra),
        .out_ea      (out_ea),
        .out_wb_en   (out_wb_en),
        .out_illegal (out_illegal)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // forms: 0 ld, 1 ldu, 2 lwa, 3 std, 4 stdu, 5 ldx, 6 ldux, 7 stdx, 8 stdux
    function automatic logic [31:0] mk_insn(input int f, input logic [4:0] rt,
                                            input logic [4:0] ra, input logic [13:0] ds);
        logic [9:0] xo;
        logic [1:0] sub;
        case (f)
            0: sub = 2'd0;
            1: sub = 2'd1;
            2: sub = 2'd2;
            3: sub = 2'd0;
            default: sub = 2'd1;
        endcase
        case (f)
            5: xo = 10'd21;
            6: xo = 10'd53;
            7: xo = 10'd149;
            default: xo = 10'd181;
        endcase
        if (f >= 5) return {6'd31, rt, ra, 5'd9, xo, 1'b0};
        else if (f >= 3) return {6'd62, rt, ra, ds, sub};
        else return {6'd58, rt, ra, ds, sub};
    endfunction

    task automatic apply(input logic v, input logic [31:0] insn,
                         input logic [63:0] b, input logic [63:0] x);
        @(negedge clk);
        in_valid = v;
        in_insn  = insn;
        in_base  = b;
        in_index = x;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_form(input int f, input logic [4:0] rt, input logic [4:0] ra,
                            input logic [13:0] ds, input logic [63:0] b, input logic [63:0] x);
        bit isx, upd, st, wrd, ill, wb;
        logic [63:0] dv, beff, ea;
        string rdec, rea, rup;
        isx = (f >= 5);
        upd = (f == 1 || f == 4 || f == 6 || f == 8);
        st  = (f == 3 || f == 4 || f == 7 || f == 8);
        wrd = (f == 2);
        ill = upd && (ra == 5'd0 || (!st && ra == rt));
        wb  = upd && !ill;
        dv   = {{50{ds[13]}}, ds} << 2;
        beff = (ra == 5'd0 && !upd) ? 64'd0 : b;
        ea   = beff + (isx ? x : dv);
        rdec = isx ? "R5" : (st ? "R4" : "R3");
        rea  = (ra == 5'd0 && !upd) ? "R7" : (isx ? "R8" : "R6");
        rup  = !upd ? "R9" : (st ? "R11" : "R10");
        apply(1'b1, mk_insn(f, rt, ra, ds), b, x);
        chk(rdec, "valid", {63'd0, out_valid}, 64'd1);
        chk(rdec, "kind/size/sext", {59'd0, out_kind, out_size, out_sext},
            {59'd0, st, (wrd ? 2'd2 : 2'd3), wrd});
        chk("R9", "rt/ra", {54'd0, out_rt, out_ra}, {54'd0, rt, ra});
        chk(rea, "ea", out_ea, ea);
        chk(rup, "illegal", {63'd0, out_illegal}, {63'd0, ill});
        chk(rup, "wb_en", {63'd0, out_wb_en}, {63'd0, wb});
    endtask

    task automatic expect_quiet(input string req, input string what);
        chk(req, {what, " valid"}, {63'd0, out_valid}, 64'd0);
        chk(req, {what, " wb/illegal"}, {62'd0, out_wb_en, out_illegal}, 64'd0);
        chk(req, {what, " ea"}, out_ea, 64'd0);
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_insn  = '0;
        in_base  = '0;
        in_index = '0;
        // R1: reset holds outputs at zero despite a valid instruction
        @(negedge clk);
        in_valid = 1'b1;
        in_insn  = mk_insn(1, 5'd3, 5'd4, 14'd7);
        in_base  = 64'h100;
        repeat (3) @(negedge clk);
        chk("R1", "valid", {63'd0, out_valid}, 64'd0);
        chk("R1", "wb_en", {63'd0, out_wb_en}, 64'd0);
        chk("R1", "ea", out_ea, 64'd0);
        chk("R1", "rt/ra", {54'd0, out_rt, out_ra}, 64'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);

        // R2: idle input with a recognised word
        apply(1'b0, mk_insn(1, 5'd3, 5'd4, 14'd7), 64'h100, 64'h0);
        expect_quiet("R2", "idle");

        // main sweep over forms, base numbers, targets and offsets
        for (int f = 0; f < 9; f++) begin
            for (int ra = 0; ra < 32; ra++) begin
                for (int rs = 0; rs < 4; rs++) begin
                    for (int dsel = 0; dsel < 3; dsel++) begin
                        logic [4:0]  rt;
                        logic [13:0] ds;
                        logic [63:0] b, x;
                        case (rs)
                            0: rt = 5'(ra);
                            1: rt = 5'd0;
                            2: rt = 5'(ra) ^ 5'h1F;
                            default: rt = 5'd13;
                        endcase
                        case (dsel)
                            0: begin ds = 14'h1FFF; b = 64'hFFFF_FFFF_FFFF_FFF0; x = 64'h20; end
                            1: begin ds = 14'h2000; b = 64'h10; x = 64'hFFFF_FFFF_FFFF_FF00; end
                            default: begin
                                ds = 14'h0005;
                                b  = 64'h0123_4567_89AB_CDE0 + 64'(ra);
                                x  = 64'h1000 + 64'(rt);
                            end
                        endcase
                        run_form(f, rt, 5'(ra), ds, b, x);
                    end
                end
            end
        end

        // R12 / R5: full extended-opcode sweep under opcode 31
        for (int xo = 0; xo < 1024; xo++) begin
            bit listed;
            listed = (xo == 21 || xo == 53 || xo == 149 || xo == 181);
            apply(1'b1, {6'd31, 5'd3, 5'd4, 5'd5, 10'(xo), 1'b0}, 64'h40, 64'h8);
            if (listed) chk("R5", "xo listed valid", {63'd0, out_valid}, 64'd1);
            else expect_quiet("R12", "xo unlisted");
        end

        // R12: unused sub-opcodes and a foreign primary opcode
        apply(1'b1, {6'd58, 5'd3, 5'd4, 14'd9, 2'd3}, 64'h40, 64'h0);
        expect_quiet("R12", "op58 sub3");
        apply(1'b1, {6'd62, 5'd3, 5'd4, 14'd9, 2'd2}, 64'h40, 64'h0);
        expect_quiet("R12", "op62 sub2");
        apply(1'b1, {6'd62, 5'd3, 5'd4, 14'd9, 2'd3}, 64'h40, 64'h0);
        expect_quiet("R12", "op62 sub3");
        apply(1'b1, {6'd32, 5'd3, 5'd4, 14'd9, 2'd1}, 64'h40, 64'h0);
        expect_quiet("R12", "op32");

        // R2: valid word followed by idle cycle
        apply(1'b1, mk_insn(0, 5'd1, 5'd2, 14'd1), 64'h0, 64'h0);
        chk("R2", "valid after one edge", {63'd0, out_valid}, 64'd1);
        @(negedge clk);
        chk("R2", "valid drops when idle", {63'd0, out_valid}, 64'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule